// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Execute Unit

This unit executes the two 32-bit multiply instructions of a small core that has a 26-bit address space. In that core the program counter shares one 32-bit register with the status flags, the interrupt masks and the mode bits. The unit produces the low 32 bits of a product. For the accumulating form it also adds a third operand. It reports which register to write back and, on request, new negative and zero flags.

A start pulse presents four register indices: destination, multiplicand, multiplier and addend. With it come the values the register file read for them, the word address of the program counter, the 8-bit status byte, and two control bits: accumulate and set-flags. When an operand index equals the program-counter index (all ones), the unit does not use the register-file value. It builds the operand from the program counter instead, and each operand position has its own rule for this. The unit accepts a start only while idle. It then runs a shift-and-add loop that retires STEP multiplier bits per cycle, and it raises `done_o` for exactly one cycle when the outputs are valid.

Top module: `mac26_unit`

## Requirements
- R1: Without accumulate, `result_o` at done equals the low 32 bits of multiplicand times multiplier.
- R2: With `mla_i` set, the addend operand is added to the product, modulo 2^32.
- R3: A multiplier index of 15 uses the word (PC+8) with bits [31:26] and [1:0] zero. The PC field sits in bits [25:2], and PC+8 wraps within 26 bits.
- R4: An addend index of 15 uses PC+8 in bits [25:2], `psr_i[7:2]` in bits [31:26] and `psr_i[1:0]` in bits [1:0].
- R5: A multiplicand index of 15 uses the same layout as R4, but with PC+12.
- R6: With set-flags, `flags_we_o` is high at done. In `flags_o` = {N,Z,C,V}, N equals result bit 31, Z is 1 exactly when the result is zero, and V equals the incoming `psr_i[4]`. C is unspecified.
- R7: Without set-flags, `flags_we_o` stays low and `flags_o` at done equals the incoming `psr_i[7:4]`.
- R8: At done, `wr_en_o` is high with `wr_idx_o` equal to the destination index, unless that index is 15; then `wr_en_o` stays low.
- R9: A start seen while idle captures all inputs at that edge. `busy_o` rises after that edge. `done_o` is high for exactly one cycle, after the 32/STEP-th following edge. `busy_o` falls one edge later.
- R10: A start seen while busy, including the done cycle, is ignored. The pending result keeps its first operands.
- R11: While reset is held, `busy_o`, `done_o`, `wr_en_o` and `flags_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| mla_i | input | 1 | Accumulate form: add the addend operand |
| setflags_i | input | 1 | Update N and Z from the result |
| dst_idx_i | input | 4 | Destination register index |
| mcand_idx_i | input | 4 | Multiplicand register index |
| mplier_idx_i | input | 4 | Multiplier register index |
| addend_idx_i | input | 4 | Addend register index |
| mcand_val_i | input | 32 | Register-file value for the multiplicand |
| mplier_val_i | input | 32 | Register-file value for the multiplier |
| addend_val_i | input | 32 | Register-file value for the addend |
| pc_word_i | input | 24 | Program counter word address (byte address bits [25:2]) |
| psr_i | input | 8 | Status byte {N,Z,C,V,I,F,mode[1:0]} |
| busy_o | output | 1 | Unit is not idle |
| done_o | output | 1 | One-cycle pulse: result and flags are valid |
| result_o | output | 32 | Multiply(-accumulate) result |
| wr_en_o | output | 1 | Register write-back request |
| wr_idx_o | output | 4 | Write-back register index |
| flags_we_o | output | 1 | Flag update request |
| flags_o | output | 4 | New {N,Z,C,V} |

## Verification
The bench builds the unit with STEP = 4, so every operation takes eight iterations. With that setting it can place a second start in the middle of the loop and also in the done cycle, and it can issue back-to-back operations within a short run. It keeps 32-bit data and 26-bit addresses, which makes the R15 word layouts reachable, including PC wrap-around at the top of the address space. The bench mixes directed cases with a few dozen random operations against a behavioural model. Some of the random operations put index 15 in each operand position.

// File: rtl/mac26_pkg.sv
package mac26_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } mac_state_e;
endpackage

// File: rtl/mac26_opsel.sv
// Operand steering: replaces register-file values by the program-counter
// word when an index names the PC, each position with its own view.
module mac26_opsel #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 26,
   parameter int IDX_W  = 4,
   localparam int PCF_W = ADDR_W - 2,
   localparam int PSR_W = DATA_W - PCF_W
) (
   input  logic              mla_i,
   input  logic [IDX_W-1:0]  mcand_idx_i,
   input  logic [IDX_W-1:0]  mplier_idx_i,
   input  logic [IDX_W-1:0]  addend_idx_i,
   input  logic [DATA_W-1:0] mcand_val_i,
   input  logic [DATA_W-1:0] mplier_val_i,
   input  logic [DATA_W-1:0] addend_val_i,
   input  logic [PCF_W-1:0]  pc_word_i,
   input  logic [PSR_W-1:0]  psr_i,
   output logic [DATA_W-1:0] mcand_o,
   output logic [DATA_W-1:0] mplier_o,
   output logic [DATA_W-1:0] addend_o
);
   localparam logic [IDX_W-1:0] PC_IDX = '1;
   localparam int HI_W = PSR_W - 2;

   logic [PCF_W-1:0]  pc_plus8, pc_plus12;
   logic [DATA_W-1:0] word_bare8, word_psr8, word_psr12;

   assign pc_plus8   = pc_word_i + PCF_W'(2);
   assign pc_plus12  = pc_word_i + PCF_W'(3);
   assign word_bare8 = {{HI_W{1'b0}}, pc_plus8, 2'b00};
   assign word_psr8  = {psr_i[PSR_W-1:2], pc_plus8, psr_i[1:0]};
   assign word_psr12 = {psr_i[PSR_W-1:2], pc_plus12, psr_i[1:0]};

   assign mcand_o  = (mcand_idx_i  == PC_IDX) ? word_psr12 : mcand_val_i;
   assign mplier_o = (mplier_idx_i == PC_IDX) ? word_bare8 : mplier_val_i;

   always_comb begin
      if (!mla_i)                      addend_o = '0;
      else if (addend_idx_i == PC_IDX) addend_o = word_psr8;
      else                             addend_o = addend_val_i;
   end
endmodule

// File: rtl/mac26_iter.sv
// Shift-and-add core retiring STEP multiplier bits per cycle.
module mac26_iter #(
   parameter int DATA_W = 32,
   parameter int STEP   = 2,
   localparam int ITER  = DATA_W / STEP,
   localparam int CNT_W = $clog2(ITER + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              run_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] c_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              last_o
);
   logic [DATA_W-1:0] acc_q, mc_q, mp_q, pp;
   logic [CNT_W-1:0]  cnt_q;

   if (STEP == 1) begin : g_serial
      assign pp = mp_q[0] ? mc_q : '0;
   end else begin : g_multi
      always_comb begin
         pp = '0;
         for (int j = 0; j < STEP; j++) begin
            if (mp_q[j]) pp = pp + (mc_q << j);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         mc_q  <= '0;
         mp_q  <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         acc_q <= c_i;
         mc_q  <= a_i;
         mp_q  <= b_i;
         cnt_q <= '0;
      end else if (run_i) begin
         acc_q <= acc_q + pp;
         mc_q  <= mc_q << STEP;
         mp_q  <= mp_q >> STEP;
         cnt_q <= (cnt_q == CNT_W'(ITER - 1)) ? '0 : cnt_q + 1'b1;
      end
   end

   assign sum_o  = acc_q;
   assign last_o = run_i && (cnt_q == CNT_W'(ITER - 1));

   AST_ITER_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(ITER)); // R9
   AST_LOAD_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/mac26_unit.sv
module mac26_unit
   import mac26_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 26,
   parameter int IDX_W  = 4,
   parameter int STEP   = 2,
   localparam int PCF_W = ADDR_W - 2,
   localparam int PSR_W = DATA_W - PCF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mla_i,
   input  logic              setflags_i,
   input  logic [IDX_W-1:0]  dst_idx_i,
   input  logic [IDX_W-1:0]  mcand_idx_i,
   input  logic [IDX_W-1:0]  mplier_idx_i,
   input  logic [IDX_W-1:0]  addend_idx_i,
   input  logic [DATA_W-1:0] mcand_val_i,
   input  logic [DATA_W-1:0] mplier_val_i,
   input  logic [DATA_W-1:0] addend_val_i,
   input  logic [PCF_W-1:0]  pc_word_i,
   input  logic [PSR_W-1:0]  psr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] result_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic              flags_we_o,
   output logic [3:0]        flags_o
);
   localparam logic [IDX_W-1:0] PC_IDX = '1;

   if (DATA_W != ADDR_W + 6) begin : g_bad_layout
      $error("mac26_unit: DATA_W must equal ADDR_W + 6");
   end
   if (STEP < 1 || (DATA_W % STEP) != 0) begin : g_bad_step
      $error("mac26_unit: STEP must divide DATA_W");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("mac26_unit: IDX_W must be positive");
   end

   mac_state_e        state_q;
   logic [IDX_W-1:0]  dst_q;
   logic              setf_q;
   logic [3:0]        nzcv_q;
   logic              accept, last;
   logic [DATA_W-1:0] op_a, op_b, op_c, sum;

   assign accept = start_i && (state_q == ST_IDLE);

   mac26_opsel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_opsel (
      .mla_i        (mla_i),
      .mcand_idx_i  (mcand_idx_i),
      .mplier_idx_i (mplier_idx_i),
      .addend_idx_i (addend_idx_i),
      .mcand_val_i  (mcand_val_i),
      .mplier_val_i (mplier_val_i),
      .addend_val_i (addend_val_i),
      .pc_word_i    (pc_word_i),
      .psr_i        (psr_i),
      .mcand_o      (op_a),
      .mplier_o     (op_b),
      .addend_o     (op_c)
   );

   mac26_iter #(.DATA_W(DATA_W), .STEP(STEP)) u_iter (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .run_i  (state_q == ST_RUN),
      .a_i    (op_a),
      .b_i    (op_b),
      .c_i    (op_c),
      .sum_o  (sum),
      .last_o (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dst_q   <= '0;
         setf_q  <= 1'b0;
         nzcv_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_RUN;
               dst_q   <= dst_idx_i;
               setf_q  <= setflags_i;
               nzcv_q  <= psr_i[PSR_W-1 -: 4];
            end
            ST_RUN:  if (last) state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = (state_q == ST_DONE);
   assign result_o   = sum;
   assign wr_idx_o   = dst_q;
   assign wr_en_o    = done_o && (dst_q != PC_IDX);
   assign flags_we_o = done_o && setf_q;
   assign flags_o    = setf_q ? {sum[DATA_W-1], (sum == '0), nzcv_q[1:0]} : nzcv_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(state_q == ST_RUN)); // R9
   AST_IDLE_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o); // R9
   AST_NO_PC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (wr_idx_o != PC_IDX)); // R8
   AST_WE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o || flags_we_o) |-> done_o); // R6
   AST_Z_MATCHES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we_o |-> (flags_o[2] == (result_o == '0))); // R6
   AST_N_MATCHES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we_o |-> (flags_o[3] == result_o[DATA_W-1])); // R6
endmodule

// File: tb/mac26_unit_bench.sv
`timescale 1ns/1ps
module mac26_unit_bench;
   localparam int STEP_B = 4;
   localparam int ITER_B = 32 / STEP_B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, mla_i = 1'b0, setflags_i = 1'b0;
   logic [3:0]  dst_idx_i = '0, mcand_idx_i = '0, mplier_idx_i = '0, addend_idx_i = '0;
   logic [31:0] mcand_val_i = '0, mplier_val_i = '0, addend_val_i = '0;
   logic [23:0] pc_word_i = '0;
   logic [7:0]  psr_i = '0;
   logic        busy_o, done_o, wr_en_o, flags_we_o;
   logic [31:0] result_o;
   logic [3:0]  wr_idx_o, flags_o;

   always #2.5 clk = ~clk;

   mac26_unit #(.STEP(STEP_B)) u_mac26_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mla_i(mla_i),
      .setflags_i(setflags_i), .dst_idx_i(dst_idx_i), .mcand_idx_i(mcand_idx_i),
      .mplier_idx_i(mplier_idx_i), .addend_idx_i(addend_idx_i),
      .mcand_val_i(mcand_val_i), .mplier_val_i(mplier_val_i),
      .addend_val_i(addend_val_i), .pc_word_i(pc_word_i), .psr_i(psr_i),
      .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .wr_en_o(wr_en_o),
      .wr_idx_o(wr_idx_o), .flags_we_o(flags_we_o), .flags_o(flags_o)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Operand words built from the requirement text (R3, R4, R5).
   function automatic logic [31:0] pc_word(input logic [23:0] pcw, input logic [7:0] psr,
                                           input int words_ahead, input bit with_psr);
      logic [23:0] p;
      p = pcw + 24'(words_ahead);
      return with_psr ? {psr[7:2], p, psr[1:0]} : {6'd0, p, 2'd0};
   endfunction

   // Behavioural reference model, updated on every rising edge.
   int          m_state = 0, m_cnt = 0;
   logic [31:0] e_res;
   logic        e_we, e_s, e_v;
   logic [3:0]  e_idx, e_flags;
   string       e_tag = "";
   string       cur_tag = "";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0;
         m_cnt   = 0;
      end else if (m_state == 0) begin
         if (start_i) begin
            logic [31:0] a, b, c;
            a = (mcand_idx_i  == 4'd15) ? pc_word(pc_word_i, psr_i, 3, 1) : mcand_val_i;
            b = (mplier_idx_i == 4'd15) ? pc_word(pc_word_i, psr_i, 2, 0) : mplier_val_i;
            c = !mla_i ? 32'd0 :
                (addend_idx_i == 4'd15) ? pc_word(pc_word_i, psr_i, 2, 1) : addend_val_i;
            e_res   = a * b + c;
            e_we    = (dst_idx_i != 4'd15);
            e_idx   = dst_idx_i;
            e_s     = setflags_i;
            e_v     = psr_i[4];
            e_flags = psr_i[7:4];
            e_tag   = cur_tag;
            m_state = 1;
            m_cnt   = ITER_B;
         end
      end else if (m_state == 1) begin
         m_cnt--;
         if (m_cnt == 0) m_state = 2;
      end else begin
         m_state = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R9 busy", 32'(busy_o), 32'(m_state != 0));
         chk("R9 done pulse", 32'(done_o), 32'(m_state == 2));
         if (m_state == 2) begin
            chk({e_tag, " result"}, result_o, e_res);
            chk("R8 write enable", 32'(wr_en_o), 32'(e_we));
            if (e_we) chk("R8 write index", 32'(wr_idx_o), 32'(e_idx));
            if (e_s) begin
               chk("R6 flag write", 32'(flags_we_o), 32'd1);
               chk("R6 N Z V", 32'({flags_o[3:2], flags_o[0]}),
                   32'({e_res[31], (e_res == 32'd0), e_v}));
            end else begin
               chk("R7 flag write", 32'(flags_we_o), 32'd0);
               chk("R7 flags kept", 32'(flags_o), 32'(e_flags));
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected <= 60000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // intrude: 0 none, 1 extra start mid-loop, 2 extra start in done cycle
   task automatic op(input string tag, input bit mla, input bit s, input logic [3:0] dst,
                     input logic [3:0] ia, input logic [3:0] ib, input logic [3:0] ic,
                     input logic [31:0] va, input logic [31:0] vb, input logic [31:0] vc,
                     input logic [23:0] pcw, input logic [7:0] psr, input int intrude);
      @(negedge clk);
      cur_tag = tag;
      mla_i = mla; setflags_i = s; dst_idx_i = dst;
      mcand_idx_i = ia; mplier_idx_i = ib; addend_idx_i = ic;
      mcand_val_i = va; mplier_val_i = vb; addend_val_i = vc;
      pc_word_i = pcw; psr_i = psr; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (intrude == 1) begin
         @(negedge clk);
         mcand_val_i = ~va; mplier_val_i = vb + 32'd77; dst_idx_i = 4'd3;
         setflags_i = ~s; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      if (intrude == 2) begin
         while (m_state != 2) @(negedge clk);
         mcand_val_i = ~va; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (m_state != 0) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 busy in reset", 32'(busy_o), 32'd0);
      chk("R11 done in reset", 32'(done_o), 32'd0);
      chk("R11 write enable in reset", 32'(wr_en_o), 32'd0);
      chk("R11 flag write in reset", 32'(flags_we_o), 32'd0);
      rst_n = 1'b1;

      op("R1 plain", 0, 0, 4'd2, 4'd0, 4'd1, 4'd5, 32'd1234, 32'd5678, 32'hDEAD, 24'h0, 8'hA5, 0);
      op("R1 wrap", 0, 1, 4'd4, 4'd0, 4'd1, 4'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 24'h0, 8'h10, 0);
      op("R1 zero", 0, 1, 4'd6, 4'd0, 4'd1, 4'd5, 32'h8000_0000, 32'd2, 32'd9, 24'h0, 8'h50, 0);
      op("R2 mla", 1, 1, 4'd7, 4'd0, 4'd1, 4'd5, 32'h7FFF_0000, 32'd3, 32'h1234_5678, 24'h0, 8'h00, 0);
      op("R2 mla negative", 1, 0, 4'd8, 4'd9, 4'd10, 4'd11, 32'd5, 32'd6, 32'hFFFF_FF00, 24'h0, 8'hF3, 0);
      op("R3 mplier pc", 0, 0, 4'd1, 4'd2, 4'd15, 4'd3, 32'd3, 32'hFFFF_FFFF, 32'd0, 24'h12_3456, 8'hFF, 0);
      op("R3 mplier pc wrap", 0, 1, 4'd1, 4'd2, 4'd15, 4'd3, 32'd1, 32'd0, 32'd0, 24'hFF_FFFF, 8'hC3, 0);
      op("R4 addend pc", 1, 0, 4'd1, 4'd2, 4'd3, 4'd15, 32'd0, 32'd0, 32'd0, 24'h00_ABCD, 8'hB6, 0);
      op("R4 addend pc sum", 1, 1, 4'd1, 4'd2, 4'd3, 4'd15, 32'd7, 32'd9, 32'd0, 24'hFF_FFFE, 8'h29, 0);
      op("R5 mcand pc", 0, 0, 4'd1, 4'd15, 4'd3, 4'd4, 32'd0, 32'd1, 32'd0, 24'hFF_FFFE, 8'h6E, 0);
      op("R5 mcand pc scaled", 1, 1, 4'd1, 4'd15, 4'd3, 4'd15, 32'd0, 32'd5, 32'd0, 24'h02_0000, 8'h9A, 0);
      op("R8 pc destination", 0, 1, 4'd15, 4'd0, 4'd1, 4'd2, 32'd10, 32'd20, 32'd0, 24'h0, 8'h40, 0);
      op("R7 no flags", 1, 0, 4'd5, 4'd0, 4'd1, 4'd2, 32'd0, 32'd0, 32'd0, 24'h0, 8'h70, 0);
      op("R10 start mid loop", 1, 1, 4'd9, 4'd0, 4'd1, 4'd2, 32'h0101_0101, 32'h0F0F, 32'd3, 24'h0, 8'h10, 1);
      op("R10 start at done", 0, 0, 4'd12, 4'd0, 4'd1, 4'd2, 32'h0000_FFFF, 32'h0001_0001, 32'd0, 24'h0, 8'h80, 2);

      for (int k = 0; k < 40; k++) begin
         logic [3:0] ia, ib, ic, d;
         ia = ($urandom % 4 == 0) ? 4'd15 : 4'($urandom % 15);
         ib = ($urandom % 4 == 0) ? 4'd15 : 4'($urandom % 15);
         ic = ($urandom % 4 == 0) ? 4'd15 : 4'($urandom % 15);
         d  = 4'($urandom);
         op("R1 R2 random", 1'($urandom), 1'($urandom), d, ia, ib, ic,
            $urandom, $urandom, $urandom, 24'($urandom), 8'($urandom), 0);
      end

      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule